// File: doc/BRIEF.md
# USB Bus Reset and Keep-Alive Detector

This block samples the raw D+ and D- lines of a low- or full-speed USB segment and times every single-ended-zero (SE0) interval, that is, every stretch with both lines low. The interval runs from the first SE0 sample to the first sample in which either line is high again. When the interval ends, the block classifies it by length. A long SE0 is a bus reset. A medium SE0 seen while the bus runs at low speed is a keep-alive. Each verdict comes out as a one-cycle pulse.

The block also tracks the bus speed for a downstream bit sampler. A two-bit mode input fixes the speed at full or low, or selects automatic detection. In automatic mode the speed follows the polarity of the idle line: D+ high means full speed and D- high means low speed. The idle state is read when the block first leaves reset and again each time a classified SE0 ends. Both length thresholds are computed at elaboration from the sample-clock frequency. The line inputs pass through a synchronizer, and samples taken before that synchronizer has filled are discarded.

Top module: `usb_bus_event_det`

## Requirements
- R1: When an SE0 lasting more than RST_CYC samples ends (RST_CYC = CLK_HZ * RESET_NS / 1e9, which is 25 at 10 MHz), reset_o goes high for exactly one cycle.
- R2: When an SE0 lasting more than KA_CYC samples and at most RST_CYC samples ends (KA_CYC = CLK_HZ * KEEPALIVE_NS / 1e9, which is 12 at 10 MHz), keepalive_o pulses for one cycle if speed_low_o was 1 while the SE0 was ending. This holds even when the exit polarity then switches the speed to full.
- R3: An SE0 in the keep-alive length range produces no pulse while speed_low_o is 0.
- R4: An SE0 of at most KA_CYC samples produces no pulse.
- R5: An SE0 of exactly one sample is not classified. It gives no pulse and does not change speed_low_o. Idle line states that are not preceded by a classified SE0 also leave the speed unchanged.
- R6: In automatic mode (mode_i 2'b00 or 2'b11), the end of an SE0 of two or more samples sets the speed from the exit state. dp=1,dm=0 gives speed_low_o=0 and dp=0,dm=1 gives speed_low_o=1.
- R7: In automatic mode, the first valid sample after reset seeds the speed from the idle polarity, using the same encoding as R6.
- R8: In fixed mode, speed_low_o is 0 for mode_i 2'b01 (full) and 1 for mode_i 2'b10 (low), whatever the exit polarity.
- R9: In automatic mode, a bus reset that exits to SE1 (dp=1,dm=1) returns the speed to its full-speed default. A non-reset SE0 that exits to SE1 leaves the speed unchanged.
- R10: The duration counter saturates, so an SE0 of any length above RST_CYC, including one far beyond the counter range, still yields a reset.
- R11: reset_o and keepalive_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Raw D+ line |
| dm_i | input | 1 | Raw D- line |
| mode_i | input | 2 | Speed mode: 00 auto, 01 full, 10 low, 11 auto |
| reset_o | output | 1 | One-cycle pulse when a bus reset has ended |
| keepalive_o | output | 1 | One-cycle pulse when a low-speed keep-alive has ended |
| speed_low_o | output | 1 | Current speed: 1 means low speed, 0 means full speed |

## Verification
SE0 lengths are driven on both sides of each threshold: KA_CYC and KA_CYC+1, RST_CYC and RST_CYC+1. This separates "no event", "keep-alive" and "reset", and a run far past the counter range separates a saturating counter from a wrapping one. The single-sample and two-sample SE0 cases show whether the classification guard sits at the right length. The exit state is varied between full idle, low idle and SE1 in automatic mode, which tells polarity-driven speed updates apart from reset-driven restores and from a mode that ignores polarity. The same lengths repeated in both fixed modes confirm that keep-alive depends on the speed and not on the line polarity.

// File: rtl/usb_bus_event_pkg.sv
package usb_bus_event_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_FULL  = 2'b01,
    MODE_LOW   = 2'b10,
    MODE_AUTO2 = 2'b11
  } speed_mode_e;

  // line code {dp, dm}
  typedef enum logic [1:0] {
    LINE_SE0    = 2'b00,
    LINE_LS_IDL = 2'b01,
    LINE_FS_IDL = 2'b10,
    LINE_SE1    = 2'b11
  } line_e;

  function automatic int unsigned ns_to_cycles(int unsigned hz, int unsigned ns);
    logic [63:0] prod;
    prod = 64'(hz) * 64'(ns);
    return 32'(prod / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  output logic dp_o,
  output logic dm_o,
  output logic valid_o
);

  logic [1:0]        stg_q [STAGES];
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q[0] <= 2'b00;
      fill_q   <= '0;
    end else begin
      stg_q[0] <= {dp_i, dm_i};
      fill_q   <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 2'b00;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign dp_o    = stg_q[STAGES-1][1];
  assign dm_o    = stg_q[STAGES-1][0];
  assign valid_o = fill_q[STAGES-1];

endmodule

// File: rtl/usb_se0_timer.sv
module usb_se0_timer #(
  parameter int unsigned MAX_CNT = 26,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          se0_i,
  output logic          end_o,
  output logic [CW-1:0] dur_o
);

  logic [CW-1:0] cnt_q;
  logic          in_se0;

  assign in_se0 = (cnt_q != '0);
  assign end_o  = valid_i && !se0_i && in_se0;
  assign dur_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      if (!se0_i)                      cnt_q <= '0;
      else if (cnt_q != CW'(MAX_CNT))  cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/usb_speed_track.sv
module usb_speed_track
  import usb_bus_event_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic [1:0] mode_i,
  input  logic       upd_i,
  input  logic       bus_rst_i,
  output logic       speed_low_o
);

  logic  auto_low_q;
  logic  seeded_q;
  logic  seed;
  line_e line;

  assign line = line_e'({dp_i, dm_i});
  assign seed = valid_i && !seeded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_low_q <= 1'b0;
      seeded_q   <= 1'b0;
    end else begin
      if (seed) seeded_q <= 1'b1;
      if (seed || upd_i) begin
        case (line)
          LINE_FS_IDL: auto_low_q <= 1'b0;
          LINE_LS_IDL: auto_low_q <= 1'b1;
          default:     if (upd_i && bus_rst_i) auto_low_q <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (speed_mode_e'(mode_i))
      MODE_FULL: speed_low_o = 1'b0;
      MODE_LOW:  speed_low_o = 1'b1;
      default:   speed_low_o = auto_low_q;
    endcase
  end

endmodule

// File: rtl/usb_bus_event_det.sv
module usb_bus_event_det
  import usb_bus_event_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 48_000_000,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RESET_NS     = 2500,
  parameter int unsigned KEEPALIVE_NS = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic [1:0] mode_i,
  output logic       reset_o,
  output logic       keepalive_o,
  output logic       speed_low_o
);

  localparam int unsigned RST_CYC = ns_to_cycles(CLK_HZ, RESET_NS);
  localparam int unsigned KA_CYC  = ns_to_cycles(CLK_HZ, KEEPALIVE_NS);
  localparam int unsigned SAT_CNT = RST_CYC + 1;
  localparam int unsigned CW      = $clog2(SAT_CNT + 1);

  logic          line_dp, line_dm, line_valid, line_se0;
  logic          se0_end;
  logic [CW-1:0] se0_dur;
  logic          classify, is_long, is_mid;
  logic          reset_q, ka_q;

  usb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dp_i    (dp_i),
    .dm_i    (dm_i),
    .dp_o    (line_dp),
    .dm_o    (line_dm),
    .valid_o (line_valid)
  );

  assign line_se0 = !line_dp && !line_dm;

  usb_se0_timer #(.MAX_CNT(SAT_CNT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (line_valid),
    .se0_i   (line_se0),
    .end_o   (se0_end),
    .dur_o   (se0_dur)
  );

  // single-sample SE0 is a plain line event
  assign classify = se0_end && (se0_dur > CW'(1));
  assign is_long  = se0_dur > CW'(RST_CYC);
  assign is_mid   = se0_dur > CW'(KA_CYC);

  usb_speed_track u_speed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (line_valid),
    .dp_i        (line_dp),
    .dm_i        (line_dm),
    .mode_i      (mode_i),
    .upd_i       (classify),
    .bus_rst_i   (is_long),
    .speed_low_o (speed_low_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_q <= 1'b0;
      ka_q    <= 1'b0;
    end else begin
      reset_q <= classify && is_long;
      ka_q    <= classify && !is_long && is_mid && speed_low_o;
    end
  end

  assign reset_o     = reset_q;
  assign keepalive_o = ka_q;

endmodule

// File: rtl/usb_bus_event_chk.sv
module usb_bus_event_chk #(
  parameter int unsigned RST_CYC = 25,
  parameter int unsigned KA_CYC  = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       se0_i,
  input logic [1:0] mode_i,
  input logic       reset_o,
  input logic       keepalive_o,
  input logic       speed_low_o
);

  logic [15:0] run_q;
  logic        run_end, end_long, end_mid, end_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (valid_i && !se0_i)       run_q <= '0;
    else if (valid_i && run_q != '1)  run_q <= run_q + 16'd1;
  end

  assign run_end  = valid_i && !se0_i && (run_q != '0);
  assign end_one  = run_end && (run_q == 16'd1);
  assign end_long = run_end && (run_q > 16'(RST_CYC)) && (run_q > 16'd1);
  assign end_mid  = run_end && (run_q > 16'(KA_CYC)) && (run_q <= 16'(RST_CYC)) && (run_q > 16'd1);

  p_rst_only_long_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |-> $past(end_long));
  p_long_gives_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(end_long) |-> reset_o);
  p_ka_only_mid_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keepalive_o |-> $past(end_mid && speed_low_o));
  p_mid_low_gives_ka_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(end_mid && speed_low_o) |-> keepalive_o);
  p_one_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(end_one) && $stable(mode_i) |-> $stable(speed_low_o) && !reset_o && !keepalive_o);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_o && keepalive_o));

endmodule

bind usb_bus_event_det usb_bus_event_chk #(.RST_CYC(RST_CYC), .KA_CYC(KA_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (line_valid),
  .se0_i       (line_se0),
  .mode_i      (mode_i),
  .reset_o     (reset_o),
  .keepalive_o (keepalive_o),
  .speed_low_o (speed_low_o)
);

// File: tb/usb_bus_event_det_tb.sv
module usb_bus_event_det_tb;

  localparam int unsigned CLK_HZ = 10_000_000;
  localparam int RST_N = (CLK_HZ / 100_000) * 25 / 100;
  localparam int KA_N  = (CLK_HZ / 100_000) * 12 / 100;

  typedef struct {
    int    kind;   // 1 reset, 2 keep-alive
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp = 1'b0, dm = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       reset_o, keepalive_o, speed_low_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R4";
  exp_t  exp_q[$];

  always #5 clk = ~clk;

  usb_bus_event_det #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dp_i        (dp),
    .dm_i        (dm),
    .mode_i      (mode),
    .reset_o     (reset_o),
    .keepalive_o (keepalive_o),
    .speed_low_o (speed_low_o)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && (reset_o || keepalive_o)) begin
      int act;
      act = reset_o ? (keepalive_o ? 3 : 1) : 2;
      checks++;
      if (act == 3) begin
        errors++;
        $display("FAIL R11 both pulses high: act=%0d exp=single", act);
      end
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected pulse: act=%0d exp=none", cur_req, act);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (act != e.kind) begin
          errors++;
          $display("FAIL %s pulse kind: act=%0d exp=%0d", e.req, act, e.kind);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive SE0 for n samples, then exit state; exp_kind 0 means no pulse
  task automatic se0(int n, logic edp, logic edm, int exp_kind, string req);
    cur_req = req;
    if (exp_kind != 0) exp_q.push_back('{kind: exp_kind, req: req});
    @(negedge clk);
    dp = 1'b0; dm = 1'b0;
    cyc(n);
    dp = edp; dm = edm;
    cyc(8);
    chk({req, " missing pulses"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    fork
      begin
        repeat (100_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    cyc(3);
    chk("R1 reset_o in reset", int'(reset_o), 0);
    chk("R2 keepalive_o in reset", int'(keepalive_o), 0);
    rst_n = 1'b1;
    cyc(6);
    chk("R7 seed low idle", int'(speed_low_o), 1);

    se0(KA_N + 1, 1'b0, 1'b1, 2, "R2");
    se0(KA_N,     1'b0, 1'b1, 0, "R4");
    se0(RST_N,    1'b0, 1'b1, 2, "R2");
    se0(RST_N + 1, 1'b0, 1'b1, 1, "R1");
    chk("R6 low after reset exit", int'(speed_low_o), 1);

    se0(1, 1'b1, 1'b0, 0, "R5");
    cyc(10);
    chk("R5 speed unchanged", int'(speed_low_o), 1);
    se0(2, 1'b1, 1'b0, 0, "R6");
    chk("R6 full from exit", int'(speed_low_o), 0);

    se0(20, 1'b1, 1'b0, 0, "R3");
    se0(20, 1'b0, 1'b1, 0, "R3");
    chk("R6 low from exit", int'(speed_low_o), 1);
    se0(20, 1'b1, 1'b0, 2, "R2");
    chk("R6 full after ka", int'(speed_low_o), 0);

    se0(300, 1'b1, 1'b0, 1, "R10");

    se0(5, 1'b0, 1'b1, 0, "R6");
    chk("R6 low", int'(speed_low_o), 1);
    se0(RST_N + 5, 1'b1, 1'b1, 1, "R9");
    chk("R9 reset restores full", int'(speed_low_o), 0);
    se0(5, 1'b0, 1'b1, 0, "R6");
    se0(5, 1'b1, 1'b1, 0, "R9");
    chk("R9 plain SE1 exit holds", int'(speed_low_o), 1);
    dp = 1'b0; dm = 1'b1;
    cyc(4);

    mode = 2'b01;
    cyc(2);
    chk("R8 fixed full", int'(speed_low_o), 0);
    se0(5, 1'b0, 1'b1, 0, "R8");
    chk("R8 full ignores polarity", int'(speed_low_o), 0);
    se0(15, 1'b0, 1'b1, 0, "R3");
    mode = 2'b10;
    cyc(2);
    chk("R8 fixed low", int'(speed_low_o), 1);
    se0(15, 1'b1, 1'b0, 2, "R2");
    chk("R8 low ignores polarity", int'(speed_low_o), 1);
    se0(RST_N + 1, 1'b1, 1'b0, 1, "R1");
    chk("R8 low after reset", int'(speed_low_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule